// File: doc/BRIEF.md
# Programmable Watchdog Down-Counter

This block is a 32-bit down-counter that a network controller uses as a general-purpose watchdog. Software sees the count as two 16-bit halves that it can write and read. A start strobe and a stop strobe set two command bits, and these decide whether the counter runs. While it runs, the count drops by one on each tick. A built-in prescaler derives the tick from the system clock. With the default setting, 10 clocks of a 50 MHz clock give a 5 MHz tick, so each step is 200 ns.

When a tick finds the count at zero, the counter reloads to all ones and keeps running. The same event sets a timer-complete status bit. Software clears that bit by writing a one to it. An interrupt line shows the status bit gated by a mask bit.

Writing either half loads the new value into the count and restarts the prescaler, so the next step falls one full tick period after the write. Reading the low half also copies the high half into a shadow register. A read of the low half followed by a read of the high half therefore returns one coherent 32-bit value.

Top module: `wdt_down_counter`

## Requirements
- R1: After the synchronous reset `rst`, `halt_cmd_bit` is 1, `run_cmd_bit` is 0, the count is 0, `tc_status` is 0 and `irq` is 0.
- R2: A `cmd_start` strobe sets `run_cmd_bit` and clears `halt_cmd_bit`. The count then falls by one every CLKS_PER_TICK clocks. The first decrement lands on the CLKS_PER_TICK-th rising edge after the edge that samples the strobe.
- R3: A `cmd_stop` strobe sets `halt_cmd_bit` and clears `run_cmd_bit`. While `halt_cmd_bit` is 1, the count neither decrements nor underflows.
- R4: When `cmd_start` and `cmd_stop` arrive in the same cycle, start wins: `run_cmd_bit` becomes 1 and `halt_cmd_bit` becomes 0.
- R5: A tick that finds the count at 0 reloads both halves to 0xFFFF and sets `tc_status`. Counting continues from 0xFFFFFFFF.
- R6: A write (`wr_en`) loads `wr_data` into the low half when `wr_sel`=0 or into the high half when `wr_sel`=1, and keeps the other half. The write restarts the prescaler, so the next decrement comes CLKS_PER_TICK edges after the write edge. A write takes priority over a tick in the same cycle.
- R7: With `rd_sel`=0, `rd_data` shows the live low half. A cycle with `rd_en`=1 and `rd_sel`=0 copies the high half into a shadow register. With `rd_sel`=1, `rd_data` shows that shadow copy.
- R8: A `tc_clear` strobe clears `tc_status`. If an underflow occurs in the same cycle, the status bit stays set.
- R9: `irq` equals `tc_mask` AND `tc_status`.
- R10: A `sw_rst` strobe halts the counter: `halt_cmd_bit` becomes 1 and `run_cmd_bit` becomes 0. The count keeps its value, and `sw_rst` takes priority over a `cmd_start` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_rst | input | 1 | Software reset strobe; halts the counter |
| cmd_start | input | 1 | Start command strobe |
| cmd_stop | input | 1 | Stop command strobe |
| wr_en | input | 1 | Count half write strobe |
| wr_sel | input | 1 | Half select for write: 0 low, 1 high |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe; a low-half read captures the high half |
| rd_sel | input | 1 | Half select for read: 0 live low, 1 shadow high |
| rd_data | output | 16 | Read data |
| tc_clear | input | 1 | Write-one-to-clear strobe for the status bit |
| tc_mask | input | 1 | Interrupt mask for the timer-complete bit |
| run_cmd_bit | output | 1 | Start command bit |
| halt_cmd_bit | output | 1 | Stop command bit |
| tc_status | output | 1 | Timer-complete status bit |
| irq | output | 1 | Interrupt line |

## Verification
- **Command bits, writes and status changes** appear one edge after the sampling edge.
- **Decrements** land on the CLKS_PER_TICK-th edge after a start strobe or a write. The bench counts edges from the sampling edge and samples the low half just before and just after that edge.
- **Underflow** is reached by letting the count run down from a known value. The status bit and the reload appear on the exact tick edge, and the bench also places a clear strobe on that same edge.
- **Read data and the interrupt line** are combinational. The bench reads them 1 ns after a falling edge, and it inspects the high half only while the counter is halted, so a tick cannot race the two-cycle read.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int HALF_W  = 16;
    localparam int COUNT_W = 2 * HALF_W;

    typedef enum logic {
        HALF_LO = 1'b0,
        HALF_HI = 1'b1
    } half_e;

    typedef struct packed {
        logic run;
        logic halt;
    } cmd_bits_t;

    typedef struct packed {
        logic              en;
        half_e             sel;
        logic [HALF_W-1:0] data;
    } half_wr_t;

    function automatic logic [COUNT_W-1:0] merge_half(
        input logic [COUNT_W-1:0] cur,
        input half_wr_t           wr
    );
        logic [COUNT_W-1:0] nxt;
        nxt = cur;
        if (wr.sel == HALF_HI) nxt[COUNT_W-1:HALF_W] = wr.data;
        else                   nxt[HALF_W-1:0]       = wr.data;
        return nxt;
    endfunction
endpackage

// File: rtl/wdt_cmd_ctrl.sv
module wdt_cmd_ctrl
    import wdt_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_rst,
    input  logic      cmd_start,
    input  logic      cmd_stop,
    output cmd_bits_t cmd_q
);
    always_ff @(posedge clk) begin
        if (rst || sw_rst) begin
            cmd_q.run  <= 1'b0;
            cmd_q.halt <= 1'b1;
        end else if (cmd_start) begin
            cmd_q.run  <= 1'b1;
            cmd_q.halt <= 1'b0;
        end else if (cmd_stop) begin
            cmd_q.run  <= 1'b0;
            cmd_q.halt <= 1'b1;
        end
    end

    p_cmd_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(cmd_q.run && cmd_q.halt));
    p_sw_rst_halts_r10: assert property (@(posedge clk) disable iff (rst)
        sw_rst |=> (cmd_q.halt && !cmd_q.run));
    p_start_runs_r2: assert property (@(posedge clk) disable iff (rst)
        (cmd_start && !sw_rst) |=> (cmd_q.run && !cmd_q.halt));
    p_stop_halts_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_stop && !cmd_start) |=> cmd_q.halt);
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int CLKS_PER_TICK = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    output logic tick
);
    localparam int PRESC_W = (CLKS_PER_TICK > 1) ? $clog2(CLKS_PER_TICK) : 1;
    localparam logic [PRESC_W-1:0] LAST = PRESC_W'(CLKS_PER_TICK - 1);

    logic [PRESC_W-1:0] phase_q;

    assign tick = enable && !restart && (phase_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart || !enable) phase_q <= '0;
        else if (phase_q == LAST)      phase_q <= '0;
        else                           phase_q <= phase_q + 1'b1;
    end

    p_tick_needs_enable_r3: assert property (@(posedge clk) disable iff (rst)
        tick |-> enable);
    p_no_back_to_back_tick_r2: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  half_wr_t          wr,
    input  logic              rd_en,
    input  half_e             rd_sel,
    output logic [HALF_W-1:0] rd_data,
    output logic              underflow
);
    logic [COUNT_W-1:0] count_q;
    logic [HALF_W-1:0]  shadow_q;

    assign underflow = tick && !wr.en && (count_q == '0);
    assign rd_data   = (rd_sel == HALF_HI) ? shadow_q : count_q[HALF_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (wr.en) begin
            count_q <= merge_half(count_q, wr);
        end else if (tick) begin
            count_q <= count_q - COUNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                                shadow_q <= '0;
        else if (rd_en && (rd_sel == HALF_LO))  shadow_q <= count_q[COUNT_W-1:HALF_W];
    end

    p_hold_without_event_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && !wr.en) |=> $stable(count_q));
    p_decrement_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr.en && count_q != '0) |=> (count_q == $past(count_q) - COUNT_W'(1)));
    p_reload_all_ones_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && !wr.en && count_q == '0) |=> (count_q == '1));
    p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.sel == HALF_LO) |=> (count_q[HALF_W-1:0] == $past(wr.data)));
endmodule

// File: rtl/wdt_irq_ctrl.sv
module wdt_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic mask,
    output logic status,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)          status <= 1'b0;
        else if (set_evt) status <= 1'b1;
        else if (clr_evt) status <= 1'b0;
    end

    assign irq = mask & status;

    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> status);
    p_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !set_evt) |=> !status);
    p_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (status && !clr_evt) |=> status);
endmodule

// File: rtl/wdt_down_counter.sv
module wdt_down_counter
    import wdt_pkg::*;
#(
    parameter int CLKS_PER_TICK = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sw_rst,
    input  logic              cmd_start,
    input  logic              cmd_stop,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [HALF_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_sel,
    output logic [HALF_W-1:0] rd_data,
    input  logic              tc_clear,
    input  logic              tc_mask,
    output logic              run_cmd_bit,
    output logic              halt_cmd_bit,
    output logic              tc_status,
    output logic              irq
);
    cmd_bits_t cmd_q;
    half_wr_t  wr;
    logic      tick;
    logic      underflow;
    logic      restart;

    assign wr.en   = wr_en;
    assign wr.sel  = half_e'(wr_sel);
    assign wr.data = wr_data;

    assign restart = wr_en || (cmd_start && !sw_rst);

    wdt_cmd_ctrl u_cmd (
        .clk       (clk),
        .rst       (rst),
        .sw_rst    (sw_rst),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_q     (cmd_q)
    );

    wdt_prescaler #(.CLKS_PER_TICK(CLKS_PER_TICK)) u_presc (
        .clk     (clk),
        .rst     (rst),
        .enable  (!cmd_q.halt),
        .restart (restart),
        .tick    (tick)
    );

    wdt_count_core u_core (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .wr        (wr),
        .rd_en     (rd_en),
        .rd_sel    (half_e'(rd_sel)),
        .rd_data   (rd_data),
        .underflow (underflow)
    );

    wdt_irq_ctrl u_irq (
        .clk     (clk),
        .rst     (rst),
        .set_evt (underflow),
        .clr_evt (tc_clear),
        .mask    (tc_mask),
        .status  (tc_status),
        .irq     (irq)
    );

    assign run_cmd_bit  = cmd_q.run;
    assign halt_cmd_bit = cmd_q.halt;

    p_halted_no_underflow_r3: assert property (@(posedge clk) disable iff (rst)
        halt_cmd_bit |-> !underflow);
endmodule

// File: tb/wdt_down_counter_tb_top.sv
module wdt_down_counter_tb_top;
    localparam int N = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sw_rst = 0, cmd_start = 0, cmd_stop = 0;
    logic        wr_en = 0, wr_sel = 0;
    logic [15:0] wr_data = '0;
    logic        rd_en = 0, rd_sel = 0;
    logic [15:0] rd_data;
    logic        tc_clear = 0, tc_mask = 0;
    logic        run_cmd_bit, halt_cmd_bit, tc_status, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    wdt_down_counter #(.CLKS_PER_TICK(N)) dut_i (
        .clk(clk), .rst(rst), .sw_rst(sw_rst), .cmd_start(cmd_start),
        .cmd_stop(cmd_stop), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .tc_clear(tc_clear),
        .tc_mask(tc_mask), .run_cmd_bit(run_cmd_bit), .halt_cmd_bit(halt_cmd_bit),
        .tc_status(tc_status), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse(input logic st, input logic sp, input logic swr, input logic clr);
        cmd_start = st; cmd_stop = sp; sw_rst = swr; tc_clear = clr;
        @(posedge clk); @(negedge clk);
        cmd_start = 0; cmd_stop = 0; sw_rst = 0; tc_clear = 0;
    endtask

    task automatic write_half(input logic sel, input logic [15:0] d);
        wr_en = 1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 0;
    endtask

    task automatic peek_lo(output logic [15:0] v);
        rd_sel = 0; #1; v = rd_data;
    endtask

    task automatic read32(output logic [31:0] v);
        rd_en = 1; rd_sel = 0; #1; v[15:0] = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 0; rd_sel = 1; #1; v[31:16] = rd_data;
        rd_sel = 0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 halt bit", halt_cmd_bit, 1);
        check("R1 run bit", run_cmd_bit, 0);
        check("R1 status", tc_status, 0);
        check("R1 irq", irq, 0);
        read32(v);
        check("R1 count", v, 0);
    endtask

    task automatic t_load_stopped();
        logic [31:0] v; logic [15:0] lo;
        write_half(0, 16'h0005);
        write_half(1, 16'h0000);
        read32(v);
        check("R6 load", v, 32'h5);
        wait_edges(3 * N);
        peek_lo(lo);
        check("R3 frozen while halted", lo, 16'h0005);
    endtask

    task automatic t_count_and_underflow();
        logic [15:0] lo;
        pulse(1, 0, 0, 0);
        check("R2 run bit", run_cmd_bit, 1);
        check("R2 halt bit", halt_cmd_bit, 0);
        wait_edges(N - 1);
        peek_lo(lo); check("R2 before first tick", lo, 16'h0005);
        wait_edges(1);
        peek_lo(lo); check("R2 first decrement", lo, 16'h0004);
        wait_edges(4 * N);
        peek_lo(lo); check("R2 reaches zero", lo, 16'h0000);
        check("R5 no status before underflow", tc_status, 0);
        wait_edges(N);
        peek_lo(lo); check("R5 reload low", lo, 16'hFFFF);
        check("R5 status set", tc_status, 1);
        check("R9 irq masked", irq, 0);
        tc_mask = 1; #1;
        check("R9 irq unmasked", irq, 1);
        wait_edges(N);
        peek_lo(lo); check("R5 keeps counting", lo, 16'hFFFE);
        pulse(0, 0, 0, 1);
        check("R8 clear status", tc_status, 0);
        check("R9 irq after clear", irq, 0);
        tc_mask = 0;
    endtask

    task automatic t_stop();
        logic [15:0] a, b; logic [31:0] v;
        pulse(0, 1, 0, 0);
        check("R3 halt bit", halt_cmd_bit, 1);
        check("R3 run bit", run_cmd_bit, 0);
        peek_lo(a);
        wait_edges(3 * N);
        peek_lo(b);
        check("R3 count frozen", b, a);
        read32(v);
        check("R5 high half reloaded", v[31:16], 16'hFFFF);
    endtask

    task automatic t_both();
        pulse(1, 1, 0, 0);
        check("R4 start wins run", run_cmd_bit, 1);
        check("R4 start wins halt", halt_cmd_bit, 0);
        pulse(0, 1, 0, 0);
    endtask

    task automatic t_write_retime();
        logic [15:0] lo; logic [31:0] v;
        write_half(0, 16'h0100);
        write_half(1, 16'h0000);
        pulse(1, 0, 0, 0);
        wait_edges(3);
        write_half(0, 16'h0050);
        wait_edges(N - 1);
        peek_lo(lo); check("R6 retimed hold", lo, 16'h0050);
        wait_edges(1);
        peek_lo(lo); check("R6 retimed decrement", lo, 16'h004F);
        pulse(0, 1, 0, 0);
        write_half(1, 16'h1234);
        read32(v);
        check("R6 other half kept", v, 32'h1234_004F);
    endtask

    task automatic t_set_clear_race();
        logic [15:0] lo;
        write_half(1, 16'h0000);
        write_half(0, 16'h0000);
        pulse(1, 0, 0, 0);
        wait_edges(N - 1);
        pulse(0, 0, 0, 1);
        check("R8 set wins over clear", tc_status, 1);
        peek_lo(lo); check("R5 reload at race", lo, 16'hFFFF);
        pulse(0, 0, 0, 1);
        check("R8 clear after race", tc_status, 0);
        pulse(0, 1, 0, 0);
    endtask

    task automatic t_sw_rst();
        logic [15:0] a, b;
        pulse(1, 0, 0, 0);
        wait_edges(2 * N);
        pulse(1, 0, 1, 0);
        check("R10 halt bit", halt_cmd_bit, 1);
        check("R10 run bit", run_cmd_bit, 0);
        peek_lo(a);
        wait_edges(2 * N);
        peek_lo(b);
        check("R10 count kept", b, a);
    endtask

    task automatic t_shadow();
        logic [15:0] lo; logic [31:0] v;
        write_half(1, 16'h0001);
        write_half(0, 16'h0000);
        rd_en = 1; rd_sel = 0; #1; lo = rd_data;
        @(posedge clk); @(negedge clk);
        rd_en = 0;
        check("R7 live low", lo, 16'h0000);
        write_half(1, 16'h00AA);
        rd_sel = 1; #1;
        check("R7 shadow holds captured high", rd_data, 16'h0001);
        rd_sel = 0;
        read32(v);
        check("R7 coherent pair", v, 32'h00AA_0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        t_reset();
        t_load_stopped();
        t_count_and_underflow();
        t_stop();
        t_both();
        t_write_retime();
        t_set_clear_race();
        t_sw_rst();
        t_shadow();
        if (!done) begin
            done = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule